// File: doc/BRIEF.md
# Flow-Through Burst Synchronous Memory

This block is a single-port synchronous memory with 32-bit words split into four byte lanes. Either of two start strobes loads an access. One strobe belongs to the processor and the other to a cache controller. The block registers the start address and then walks the remaining three words of an aligned group of four on its own. Each step is taken when the advance input is low. The order of the steps is linear or interleaved. The read path has no output register. After the clock edge that loads or steps an address, the word at that address is on `rdata` in the same clock period.

Writes are decided per byte lane. A global write stores all four lanes. Otherwise a lane-write enable lets individual active-low lane selects pick lanes. A processor start strobe always turns its cycle into a read. A sleep input freezes the block, and chip enable is sampled whenever a new access is loaded. The address width is a parameter. The default of 10 bits keeps the array small, and setting it to 16 gives the full 64K-word configuration. The bidirectional bus is modelled as `wdata` in, and `rdata` out qualified by `rvalid`.

Top module: `fbsram_ctrl`

## Requirements
- R1: After reset the block is deselected and `rvalid` is low until an access is loaded with chip enable active.
- R2: A rising edge with `proc_start_n` or `cache_start_n` low, while `chip_en_n` is low, loads `addr` with burst count zero. The word at `addr` appears on `rdata`, with `rvalid` high when `out_en_n` is low, in the clock period that follows that edge.
- R3: With `linear_order`=1 at load, each edge with `advance_n` low and no start strobe raises the count. The low two address bits are then (start + count) mod 4, and the count wraps after the fourth beat. The upper address bits never change.
- R4: With `linear_order`=0 at load, the low two address bits of each beat are start XOR count.
- R5: An edge with `advance_n` high and no start strobe keeps the current address.
- R6: `global_wr_n` low writes all four lanes of the current address from `wdata`, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R7: With `global_wr_n` high and `lane_wr_en_n` low, lane i (bits 8i+7..8i) is written exactly when `lane_sel_n[i]` is low.
- R8: With `global_wr_n` and `lane_wr_en_n` both high, `lane_sel_n` has no effect and nothing is written.
- R9: An edge with `proc_start_n` low writes nothing and starts a read. A write may begin on an edge that has only `cache_start_n` low.
- R10: While `sleep` is high, the address, count and selection stay frozen, nothing is written, `rvalid` is low, and the contents are kept.
- R11: A start strobe with `chip_en_n` high deselects the block from the next period on. While it is deselected, `rvalid` stays low and nothing is written.
- R12: `out_en_n` high forces `rvalid` low and has no effect on the address or the contents.
- R13: With both start strobes low, the edge behaves as a processor start and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the access state |
| addr | input | ADDR_W | Start address, sampled on a start strobe |
| proc_start_n | input | 1 | Processor start strobe, active low, read only |
| cache_start_n | input | 1 | Cache-controller start strobe, active low |
| advance_n | input | 1 | Step to the next burst beat when low |
| linear_order | input | 1 | 1 = linear order, 0 = interleaved, sampled on load |
| chip_en_n | input | 1 | Chip enable, active low, sampled on load |
| global_wr_n | input | 1 | Write all lanes when low |
| lane_wr_en_n | input | 1 | Enable the per-lane selects when low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, gates `rvalid` |
| sleep | input | 1 | Power-down, freezes the block when high |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Flow-through read data |
| rvalid | output | 1 | `rdata` is being driven |

## Verification
Some properties are checked on every clock. A load captures the address and clears the count. An advance raises the count by exactly one, and a hold keeps it. Sleep freezes the access state, and a deselecting load forces `rvalid` low. The assertions cannot see the stored words, so the bench scenarios carry the rest. They show the two burst orders and the wrap, and which lanes each write mode touches. They also read back that a processor start, both strobes together, sleep, deselection and the lane selects without their enable all leave the array unchanged.

// File: rtl/fbsram_ctrl.sv
module fbsram_ctrl #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_start_n,
  input  logic              cache_start_n,
  input  logic              advance_n,
  input  logic              linear_order,
  input  logic              chip_en_n,
  input  logic              global_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              lin_q, lin_d;
  logic              load;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [LANES-1:0]  lanes, wen;

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [1:0] c,
                                                  input logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
    return {b[ADDR_W-1:2], lo};
  endfunction

  assign load = ~proc_start_n | ~cache_start_n;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    lin_d  = lin_q;
    if (load) begin
      base_d = addr;
      cnt_d  = 2'd0;
      act_d  = ~chip_en_n;
      lin_d  = linear_order;
    end else if (act_q && !advance_n) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  assign cur_addr = beat_addr(base_q, cnt_q, lin_q);
  assign nxt_addr = beat_addr(base_d, cnt_d, lin_d);

  assign lanes = !global_wr_n  ? {LANES{1'b1}} :
                 !lane_wr_en_n ? ~lane_sel_n   : '0;
  assign wen   = (!sleep && act_d && proc_start_n) ? lanes : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
      lin_q  <= 1'b1;
    end else if (!sleep) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      lin_q  <= lin_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wen[i]) mem[nxt_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign rdata  = mem[cur_addr];
  assign rvalid = act_q & ~sleep & ~out_en_n;

  assert_load_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && load) |=> (base_q == $past(addr) && cnt_q == 2'd0));

  assert_advance_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !load && act_q && !advance_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !load && advance_n) |=> ($stable(cnt_q) && $stable(base_q)));

  assert_sleep_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cnt_q) && $stable(base_q) && $stable(act_q)));

  assert_deselect_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && load && chip_en_n) |=> !rvalid);
endmodule

// File: tb/tb_fbsram_ctrl.sv
module tb_fbsram_ctrl;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          proc_start_n = 1'b1, cache_start_n = 1'b1, advance_n = 1'b1;
  logic          linear_order = 1'b1, chip_en_n = 1'b1, global_wr_n = 1'b1;
  logic          lane_wr_en_n = 1'b1, out_en_n = 1'b1, sleep = 1'b0;
  logic [3:0]    lane_sel_n = 4'hF;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  fbsram_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_start_n(proc_start_n),
    .cache_start_n(cache_start_n), .advance_n(advance_n), .linear_order(linear_order),
    .chip_en_n(chip_en_n), .global_wr_n(global_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid));

  always #5 clk = ~clk;

  typedef struct {
    logic          chk;
    logic          ev;
    logic [DW-1:0] ed;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic done   = 1'b0;

  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.chk) begin
        checks++;
        if (rvalid !== it.ev || (it.ev && rdata !== it.ed)) begin
          fails++;
          $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                   it.tag, rvalid, rdata, it.ev, it.ed);
        end
      end
    end
  end

  // strobe: 0 none, 1 processor, 2 cache, 3 both
  task automatic cyc(input int strobe, input logic adv, input logic ce, input logic lin,
                     input logic gw, input logic bwe, input logic [3:0] sel,
                     input logic oe, input logic slp, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic chk, input logic ev,
                     input logic [DW-1:0] ed, input string tag);
    exp_t it;
    @(negedge clk);
    proc_start_n  = !(strobe == 1 || strobe == 3);
    cache_start_n = !(strobe == 2 || strobe == 3);
    advance_n = adv; chip_en_n = ce; linear_order = lin; global_wr_n = gw;
    lane_wr_en_n = bwe; lane_sel_n = sel; out_en_n = oe; sleep = slp;
    addr = a; wdata = wd;
    it.chk = chk; it.ev = ev; it.ed = ed; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic rd(input int strobe, input logic adv, input logic lin,
                    input logic [AW-1:0] a, input logic [DW-1:0] ed, input string tag);
    cyc(strobe, adv, 1'b0, lin, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, a, 32'h0, 1'b1, 1'b1, ed, tag);
  endtask

  localparam logic [DW-1:0] A0 = 32'h1111_0000, A1 = 32'h1111_0001,
                            A2 = 32'h1111_0002, A3 = 32'h1111_0003;
  localparam logic [DW-1:0] A1P = 32'h11FF_00FF, B3 = 32'hB3B3_B3B3, JUNK = 32'hDEAD_BEEF;

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    cyc(0, 1, 1, 1, 1, 1, 4'hF, 0, 0, 0, 0, 1, 0, 0, "R1 reset deselected");
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 1, 1, 1, 1, 1, 4'hF, 0, 0, 0, 0, 1, 0, 0, "R1 idle after reset");
    // fill 0x10..0x13 with global writes, cache start then advance; R12 oe high
    cyc(2, 1, 0, 1, 0, 1, 4'hF, 1, 0, 10'h10, A0, 1, 0, 0, "R12 oe high hides output");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 1, 0, 10'h00, A1, 1, 0, 0, "R12 oe high hides output");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 1, 0, 10'h00, A2, 0, 0, 0, "");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 1, 0, 10'h00, A3, 0, 0, 0, "");
    // R2/R3 linear burst from 0x10 with wrap
    rd(1, 1, 1, 10'h10, A0, "R2 flow-through first beat");
    rd(0, 0, 1, 10'h00, A1, "R3 linear beat 1");
    rd(0, 0, 1, 10'h00, A2, "R3 linear beat 2");
    rd(0, 0, 1, 10'h00, A3, "R3 linear beat 3");
    rd(0, 0, 1, 10'h00, A0, "R3 linear wrap");
    // R3 linear from 0x11
    rd(1, 1, 1, 10'h11, A1, "R3 linear start 1");
    rd(0, 0, 1, 10'h00, A2, "R3 linear 1->2");
    rd(0, 0, 1, 10'h00, A3, "R3 linear 2->3");
    rd(0, 0, 1, 10'h00, A0, "R3 linear 3->0");
    // R4 interleaved from 0x11: 1,0,3,2
    rd(2, 1, 0, 10'h11, A1, "R4 interleaved start 1");
    rd(0, 0, 1, 10'h00, A0, "R4 interleaved beat 1");
    rd(0, 0, 1, 10'h00, A3, "R4 interleaved beat 2");
    rd(0, 0, 1, 10'h00, A2, "R4 interleaved beat 3");
    // R5 hold
    rd(0, 1, 1, 10'h00, A2, "R5 hold keeps address");
    rd(0, 1, 1, 10'h00, A2, "R5 hold keeps address again");
    // R7 lane write lanes 0 and 2 at 0x11 via cache start
    cyc(2, 1, 0, 1, 1, 0, 4'b1010, 0, 0, 10'h11, 32'hFFFF_FFFF, 1, 1, A1P, "R7 lane write visible");
    rd(1, 1, 1, 10'h11, A1P, "R7 lane write read back");
    // R8 lane selects without enable
    cyc(2, 1, 0, 1, 1, 1, 4'h0, 0, 0, 10'h12, 32'h0, 1, 1, A2, "R8 selects ignored");
    rd(1, 1, 1, 10'h12, A2, "R8 read back unchanged");
    // R6 global write overrides lane controls
    cyc(2, 1, 0, 1, 0, 0, 4'hF, 0, 0, 10'h13, B3, 1, 1, B3, "R6 global write all lanes");
    rd(1, 1, 1, 10'h13, B3, "R6 read back");
    // R9 processor start blocks write
    cyc(1, 1, 0, 1, 0, 0, 4'h0, 0, 0, 10'h10, JUNK, 1, 1, A0, "R9 processor start is read");
    rd(0, 1, 1, 10'h00, A0, "R9 no write landed");
    // R13 both strobes
    cyc(3, 1, 0, 1, 0, 1, 4'hF, 0, 0, 10'h11, JUNK, 1, 1, A1P, "R13 both strobes no write");
    rd(0, 1, 1, 10'h00, A1P, "R13 content kept");
    // R10 sleep
    rd(1, 1, 1, 10'h12, A2, "R10 setup");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 0, 1, 10'h00, JUNK, 1, 0, 0, "R10 sleep hides output");
    cyc(1, 0, 0, 1, 0, 1, 4'hF, 0, 1, 10'h10, JUNK, 1, 0, 0, "R10 sleep ignores strobe");
    rd(0, 1, 1, 10'h00, A2, "R10 frozen address and content");
    // R11 deselect
    cyc(2, 1, 1, 1, 1, 1, 4'hF, 0, 0, 10'h10, 0, 1, 0, 0, "R11 deselect");
    cyc(0, 0, 1, 1, 0, 1, 4'hF, 0, 0, 10'h00, JUNK, 1, 0, 0, "R11 stays quiet");
    rd(1, 1, 1, 10'h10, A0, "R11 no write while deselected");
    rd(0, 0, 1, 10'h00, A1P, "R11 no write while deselected beat 1");
    // R12 oe gating on a read
    cyc(1, 1, 0, 1, 1, 1, 4'hF, 1, 0, 10'h13, 0, 1, 0, 0, "R12 oe high");
    rd(0, 1, 1, 10'h00, B3, "R12 oe low shows data");
    cyc(0, 1, 1, 1, 1, 1, 4'hF, 1, 0, 0, 0, 0, 0, 0, "");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule